// File: doc/BRIEF.md
# Event-Gated Performance Counter Block

This block counts hardware events for performance analysis. It takes a vector of single-cycle event pulses, indexed by event number, and keeps a set of 32-bit event counters (four by default), each watching one event number chosen by software. A 64-bit cycle counter runs between two programmable hardware events: a start event and a stop event. Software reaches every register over a simple word-addressed bus with a one-cycle write strobe and a combinational read path.

All per-counter controls use one mask layout. Event counter i sits on bit i and the cycle counter sits on bit 31. This layout is shared by the enable set and clear masks, the overflow flags, the interrupt enable set and clear masks and the software increment mask. A counter that wraps from all ones to zero sets its overflow flag. The single interrupt output is high while any overflow flag is set and its interrupt enable bit is also set.

The cycle counter is gated by a two-state machine. In GATE_IDLE, a pulse on the configured start event moves it to GATE_RUN (transition START). In GATE_RUN, a pulse on the configured stop event moves it back to GATE_IDLE (transition STOP). In every other case the machine holds its state.

Top module: `perf_monitor`

## Requirements
- R1: After reset, every counter, event selector, enable bit, overflow flag, interrupt enable bit, the gate configuration and the global enable are zero, the gate is in GATE_IDLE and irq is low.
- R2: Event counter i adds one on each clock in which all of the following hold: the event numbered by its selector is high, the global enable is set and enable bit i is set. A selector value at or above the number of event inputs never counts.
- R3: A counter that wraps from all ones to zero sets its overflow flag (bit i for event counter i). The cycle counter sets bit 31 only when the full 64-bit value wraps. A carry out of its low word alone sets nothing.
- R4: A write to ENSET (address 1) sets the enable bits given in the mask. A write to ENCLR (address 2) clears them. Reading either address returns the enable bitmap, and only bits 0 to N-1 and bit 31 can read as one.
- R5: A write to OVF (address 3) clears the overflow flags whose mask bits are one, and leaves the others unchanged. A wrap in the same cycle keeps its flag set.
- R6: IESET (address 4) sets and IECLR (address 5) clears interrupt enable bits, and both read back the enable mask. irq is high exactly while some overflow flag and its interrupt enable bit are both set.
- R7: A write to SWINC (address 6) adds one to every counter whose mask bit is one, whatever the enables. A counter gains at most one per clock, even when a software increment and a hardware count arrive together.
- R8: GATECFG (address 7) holds the start event number in bits [9:0] and the stop event number in bits [25:16]. The START and STOP transitions happen on the clock edge that samples the event. Counting follows the registered state.
- R9: The cycle counter adds one per clock only when the gate is in GATE_RUN, the global enable is set and enable bit 31 is set.
- R10: CTRL (address 0): bit 0 is the global enable and reads back. Writing bit 1 as one zeroes the cycle counter, and writing bit 2 as one zeroes all event counters. Bits 1 and 2 read as zero.
- R11: Writes to CYCLO (address 8), CYCHI (address 9) and event counter i (address 16+i) take effect on the next clock and win over any increment in that cycle. Writing one half of the cycle counter keeps the other half.
- R12: Event selector i is at address 24+i and reads back zero-extended. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 5 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| events | input | NUM_EVENTS (64) | Event pulses indexed by event number |
| irq | output | 1 | Overflow interrupt |

## Verification
Event pulses are tried in four situations: with every enable set, with the per-counter enable bit clear, with the global enable clear, and with a selector that points past the event vector. Telling these apart shows which of the three gating conditions a fault removes. The cycle counter is run across start pulses, stop pulses and enable changes made while in GATE_RUN. The exact counts show whether counting follows the registered state or the raw pulse. Wrap cases use preloaded counters, so a low-word carry can be told apart from a full 64-bit wrap. They also show a set-wins race against an overflow clear, and software increments that coincide with hardware counts.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned ADDR_W       = 5;
    localparam int unsigned CYC_BIT      = 31;
    localparam int unsigned CFG_STOP_LSB = 16;

    localparam int unsigned CTRL_EN_BIT      = 0;
    localparam int unsigned CTRL_CYC_RST_BIT = 1;
    localparam int unsigned CTRL_EVT_RST_BIT = 2;

    localparam logic [ADDR_W-1:0] A_CTRL       = 5'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET     = 5'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR     = 5'd2;
    localparam logic [ADDR_W-1:0] A_OVF        = 5'd3;
    localparam logic [ADDR_W-1:0] A_IE_SET     = 5'd4;
    localparam logic [ADDR_W-1:0] A_IE_CLR     = 5'd5;
    localparam logic [ADDR_W-1:0] A_SWINC      = 5'd6;
    localparam logic [ADDR_W-1:0] A_GATE_CFG   = 5'd7;
    localparam logic [ADDR_W-1:0] A_CYC_LO     = 5'd8;
    localparam logic [ADDR_W-1:0] A_CYC_HI     = 5'd9;
    localparam logic [ADDR_W-1:0] A_EVCNT_BASE = 5'd16;
    localparam logic [ADDR_W-1:0] A_EVSEL_BASE = 5'd24;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_e;
endpackage

// File: rtl/pm_event_pick.sv
module pm_event_pick #(
    parameter int unsigned NUM_EVENTS = 64,
    parameter int unsigned EVT_W      = 10
) (
    input  logic [NUM_EVENTS-1:0] events,
    input  logic [EVT_W-1:0]      num,
    output logic                  hit
);
    // Numbers beyond the event vector never match any input.
    always_comb begin
        hit = 1'b0;
        for (int e = 0; e < NUM_EVENTS; e++) begin
            if (int'(num) == e) hit = events[e];
        end
    end
endmodule

// File: rtl/pm_evt_counter.sv
module pm_evt_counter
    import pm_pkg::*;
#(
    parameter int unsigned NUM_EVENTS = 64,
    parameter int unsigned EVT_W      = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  count_en,
    input  logic                  sw_inc,
    input  logic                  sel_wr,
    input  logic [EVT_W-1:0]      sel_wdata,
    input  logic                  cnt_wr,
    input  logic [REG_W-1:0]      cnt_wdata,
    input  logic                  clr,
    output logic [EVT_W-1:0]      sel_q,
    output logic [REG_W-1:0]      count,
    output logic                  wrap
);
    logic hit;
    logic inc;

    pm_event_pick #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_pick (
        .events (events),
        .num    (sel_q),
        .hit    (hit)
    );

    // A hardware hit and a software increment in one cycle add only one.
    assign inc  = (count_en & hit) | sw_inc;
    assign wrap = inc & ~cnt_wr & ~clr & (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            count <= '0;
        end else begin
            if (sel_wr) sel_q <= sel_wdata;
            if (cnt_wr)   count <= cnt_wdata;
            else if (clr) count <= '0;
            else if (inc) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter
    import pm_pkg::*;
#(
    parameter int unsigned NUM_EVENTS = 64,
    parameter int unsigned EVT_W      = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic [EVT_W-1:0]      start_num,
    input  logic [EVT_W-1:0]      stop_num,
    input  logic                  count_en,
    input  logic                  sw_inc,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  clr,
    output logic [2*REG_W-1:0]    count,
    output logic                  wrap,
    output logic                  running
);
    gate_state_e state_q, state_d;
    logic start_hit, stop_hit;
    logic tick;

    pm_event_pick #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_start (
        .events (events),
        .num    (start_num),
        .hit    (start_hit)
    );

    pm_event_pick #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_stop (
        .events (events),
        .num    (stop_num),
        .hit    (stop_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

    // Next state: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (start_hit) state_d = GATE_RUN;
            GATE_RUN:  if (stop_hit)  state_d = GATE_IDLE;
            default:   state_d = GATE_IDLE;
        endcase
    end

    // Outputs of the gate
    always_comb begin
        running = (state_q == GATE_RUN);
        tick    = (running & count_en) | sw_inc;
        wrap    = tick & ~wr_lo & ~wr_hi & ~clr & (&count);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count[REG_W-1:0] <= wdata;
        end else if (wr_hi) begin
            count[2*REG_W-1:REG_W] <= wdata;
        end else if (clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pm_pkg::*;
#(
    parameter int unsigned NUM_CNT    = 4,
    parameter int unsigned NUM_EVENTS = 64,
    parameter int unsigned EVT_W      = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [NUM_EVENTS-1:0] events,
    output logic                  irq
);
    // NUM_CNT up to 8 fits the address layout; EVT_W up to 16 fits the gate fields.
    localparam logic [REG_W-1:0] VALID =
        (REG_W'(1) << CYC_BIT) | REG_W'((64'd1 << NUM_CNT) - 64'd1);

    logic               glob_en;
    logic [REG_W-1:0]   en_q, ovf_q, ie_q, wrap_mask;
    logic [EVT_W-1:0]   start_q, stop_q;
    logic [NUM_CNT-1:0] evt_wrap;
    logic [REG_W-1:0]   evt_count [NUM_CNT];
    logic [EVT_W-1:0]   evt_sel   [NUM_CNT];
    logic [2*REG_W-1:0] cyc_count;
    logic               cyc_wrap, cyc_running;
    logic               wr_ctrl, wr_swinc;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_swinc = bus_wr && (bus_addr == A_SWINC);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
        pm_evt_counter #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .events    (events),
            .count_en  (glob_en & en_q[g]),
            .sw_inc    (wr_swinc & bus_wdata[g]),
            .sel_wr    (bus_wr && (bus_addr == A_EVSEL_BASE + ADDR_W'(g))),
            .sel_wdata (bus_wdata[EVT_W-1:0]),
            .cnt_wr    (bus_wr && (bus_addr == A_EVCNT_BASE + ADDR_W'(g))),
            .cnt_wdata (bus_wdata),
            .clr       (wr_ctrl & bus_wdata[CTRL_EVT_RST_BIT]),
            .sel_q     (evt_sel[g]),
            .count     (evt_count[g]),
            .wrap      (evt_wrap[g])
        );
    end

    pm_cycle_counter #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .events    (events),
        .start_num (start_q),
        .stop_num  (stop_q),
        .count_en  (glob_en & en_q[CYC_BIT]),
        .sw_inc    (wr_swinc & bus_wdata[CYC_BIT]),
        .wr_lo     (bus_wr && (bus_addr == A_CYC_LO)),
        .wr_hi     (bus_wr && (bus_addr == A_CYC_HI)),
        .wdata     (bus_wdata),
        .clr       (wr_ctrl & bus_wdata[CTRL_CYC_RST_BIT]),
        .count     (cyc_count),
        .wrap      (cyc_wrap),
        .running   (cyc_running)
    );

    always_comb begin
        wrap_mask = '0;
        wrap_mask[NUM_CNT-1:0] = evt_wrap;
        wrap_mask[CYC_BIT]     = cyc_wrap;
    end

    // Control registers; an overflow that arrives with its clear stays set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            en_q    <= '0;
            ovf_q   <= '0;
            ie_q    <= '0;
            start_q <= '0;
            stop_q  <= '0;
        end else begin
            if (wr_ctrl) glob_en <= bus_wdata[CTRL_EN_BIT];
            if (bus_wr && bus_addr == A_EN_SET) en_q <= en_q | (bus_wdata & VALID);
            if (bus_wr && bus_addr == A_EN_CLR) en_q <= en_q & ~bus_wdata;
            if (bus_wr && bus_addr == A_IE_SET) ie_q <= ie_q | (bus_wdata & VALID);
            if (bus_wr && bus_addr == A_IE_CLR) ie_q <= ie_q & ~bus_wdata;
            if (bus_wr && bus_addr == A_OVF)
                ovf_q <= (ovf_q & ~bus_wdata) | wrap_mask;
            else
                ovf_q <= ovf_q | wrap_mask;
            if (bus_wr && bus_addr == A_GATE_CFG) begin
                start_q <= bus_wdata[EVT_W-1:0];
                stop_q  <= bus_wdata[CFG_STOP_LSB +: EVT_W];
            end
        end
    end

    assign irq = |(ovf_q & ie_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:             bus_rdata[CTRL_EN_BIT] = glob_en;
            A_EN_SET, A_EN_CLR: bus_rdata = en_q;
            A_OVF:              bus_rdata = ovf_q;
            A_IE_SET, A_IE_CLR: bus_rdata = ie_q;
            A_GATE_CFG: begin
                bus_rdata[EVT_W-1:0]              = start_q;
                bus_rdata[CFG_STOP_LSB +: EVT_W]  = stop_q;
            end
            A_CYC_LO:           bus_rdata = cyc_count[REG_W-1:0];
            A_CYC_HI:           bus_rdata = cyc_count[2*REG_W-1:REG_W];
            default:            bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_addr == A_EVCNT_BASE + ADDR_W'(i)) bus_rdata = evt_count[i];
            if (bus_addr == A_EVSEL_BASE + ADDR_W'(i)) bus_rdata = REG_W'(evt_sel[i]);
        end
    end
endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import pm_pkg::*;
#(
    parameter int unsigned NUM_CNT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic               irq,
    input logic               glob_en,
    input logic [REG_W-1:0]   en_q,
    input logic [REG_W-1:0]   ovf_q,
    input logic [REG_W-1:0]   wrap_mask,
    input logic [2*REG_W-1:0] cyc_count,
    input logic               cyc_running
);
    localparam logic [REG_W-1:0] VALID =
        (REG_W'(1) << CYC_BIT) | REG_W'((64'd1 << NUM_CNT) - 64'd1);

    logic cyc_touched;
    assign cyc_touched = bus_wr && ((bus_addr == A_CYC_LO) || (bus_addr == A_CYC_HI) ||
                         ((bus_addr == A_SWINC) && bus_wdata[CYC_BIT]) ||
                         ((bus_addr == A_CTRL) && bus_wdata[CTRL_CYC_RST_BIT]));

    assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_SET) |=>
            ((en_q & $past(bus_wdata) & VALID) == ($past(bus_wdata) & VALID)));

    assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_CLR) |=> ((en_q & $past(bus_wdata)) == '0));

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mask != '0) |=> ((ovf_q & $past(wrap_mask)) == $past(wrap_mask)));

    assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OVF && wrap_mask == '0) |=>
            ((ovf_q & $past(bus_wdata)) == '0));

    assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IE_CLR && bus_wdata == '1) |=> !irq);

    assert_cyc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cyc_running && glob_en && en_q[CYC_BIT]) && !cyc_touched) |=> $stable(cyc_count));

    assert_cyc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[CTRL_CYC_RST_BIT]) |=> (cyc_count == '0));

    assert_cyc_lo_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CYC_LO) |=>
            (cyc_count[REG_W-1:0] == $past(bus_wdata) &&
             cyc_count[2*REG_W-1:REG_W] == $past(cyc_count[2*REG_W-1:REG_W])));
endmodule

bind perf_monitor pm_checker #(.NUM_CNT(NUM_CNT)) u_pm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq         (irq),
    .glob_en     (glob_en),
    .en_q        (en_q),
    .ovf_q       (ovf_q),
    .wrap_mask   (wrap_mask),
    .cyc_count   (cyc_count),
    .cyc_running (cyc_running)
);

// File: tb/perf_monitor_test.sv
module perf_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] events = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    perf_monitor uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .events    (events),
        .irq       (irq)
    );

    // Behavioural reference model, four event counters, 64 events
    bit          m_en, m_run;
    logic [31:0] m_cen, m_ovf, m_ie, m_cfg, m_cnt [4], m_sel [4];
    logic [63:0] m_cyc;
    logic [31:0] m_set, m_clr;
    localparam logic [31:0] M_VALID = 32'h8000_000F;

    function automatic bit ev(input logic [31:0] n);
        return (n < 64) ? events[n[5:0]] : 1'b0;
    endfunction

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'd0: return {31'd0, m_en};
            5'd1, 5'd2: return m_cen;
            5'd3: return m_ovf;
            5'd4, 5'd5: return m_ie;
            5'd7: return m_cfg;
            5'd8: return m_cyc[31:0];
            5'd9: return m_cyc[63:32];
            5'd16, 5'd17, 5'd18, 5'd19: return m_cnt[a - 5'd16];
            5'd24, 5'd25, 5'd26, 5'd27: return m_sel[a - 5'd24];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_run = 0; m_cen = 0; m_ovf = 0; m_ie = 0; m_cfg = 0; m_cyc = 0;
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
        end else begin
            m_set = 0;
            for (int i = 0; i < 4; i++) begin
                if (bus_wr && bus_addr == 5'(16 + i)) m_cnt[i] = bus_wdata;
                else if (bus_wr && bus_addr == 5'd0 && bus_wdata[2]) m_cnt[i] = 0;
                else if ((m_en && m_cen[i] && ev(m_sel[i])) ||
                         (bus_wr && bus_addr == 5'd6 && bus_wdata[i])) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) m_set[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
                if (bus_wr && bus_addr == 5'(24 + i)) m_sel[i] = {22'd0, bus_wdata[9:0]};
            end
            if (bus_wr && bus_addr == 5'd8) m_cyc[31:0] = bus_wdata;
            else if (bus_wr && bus_addr == 5'd9) m_cyc[63:32] = bus_wdata;
            else if (bus_wr && bus_addr == 5'd0 && bus_wdata[1]) m_cyc = 0;
            else if ((m_run && m_en && m_cen[31]) ||
                     (bus_wr && bus_addr == 5'd6 && bus_wdata[31])) begin
                if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) m_set[31] = 1'b1;
                m_cyc = m_cyc + 1;
            end
            if (!m_run) m_run = ev({22'd0, m_cfg[9:0]});
            else        m_run = !ev({22'd0, m_cfg[25:16]});
            m_clr = (bus_wr && bus_addr == 5'd3) ? bus_wdata : 32'd0;
            m_ovf = (m_ovf & ~m_clr) | m_set;
            if (bus_wr) begin
                case (bus_addr)
                    5'd0: m_en = bus_wdata[0];
                    5'd1: m_cen = m_cen | (bus_wdata & M_VALID);
                    5'd2: m_cen = m_cen & ~bus_wdata;
                    5'd4: m_ie = m_ie | (bus_wdata & M_VALID);
                    5'd5: m_ie = m_ie & ~bus_wdata;
                    5'd7: m_cfg = bus_wdata & 32'h03FF_03FF;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R12 model read", {32'd0, bus_rdata}, {32'd0, mread(bus_addr)});
            chk("R6 model irq", {63'd0, irq}, {63'd0, |(m_ovf & m_ie)});
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #8;
        chk(tag, {32'd0, bus_rdata}, {32'd0, exp});
        step();
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        #8;
        chk(tag, {63'd0, irq}, {63'd0, exp});
        step();
    endtask

    task automatic pulse(input int num, input int n);
        events = 64'd1 << num;
        repeat (n) step();
        events = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd(5'd0, 32'd0, "R1 ctrl");
        rd(5'd1, 32'd0, "R1 enable");
        rd(5'd8, 32'd0, "R1 cycle low");
        rd(5'd16, 32'd0, "R1 counter0");
        chk_irq(1'b0, "R1 irq");
        // R4 enable masks
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd2, 32'h8000_000F, "R4 set all");
        wr(5'd2, 32'h0000_0005);
        rd(5'd1, 32'h8000_000A, "R4 partial clear");
        wr(5'd2, 32'hFFFF_FFFF);
        rd(5'd1, 32'd0, "R4 clear all");
        // R2 event counting and gating
        wr(5'd24, 32'd3);
        wr(5'd25, 32'd70);
        rd(5'd25, 32'd70, "R12 selector readback");
        wr(5'd0, 32'd1);
        wr(5'd1, 32'h3);
        pulse(3, 5);
        rd(5'd16, 32'd5, "R2 five pulses");
        rd(5'd17, 32'd0, "R2 selector out of range");
        wr(5'd2, 32'h1);
        pulse(3, 3);
        rd(5'd16, 32'd5, "R2 enable bit clear");
        wr(5'd0, 32'd0);
        wr(5'd1, 32'h1);
        pulse(3, 3);
        rd(5'd16, 32'd5, "R2 global disable");
        // R7 software increment
        wr(5'd6, 32'h8000_0003);
        rd(5'd16, 32'd6, "R7 counter0");
        rd(5'd17, 32'd1, "R7 counter1");
        rd(5'd8, 32'd1, "R7 cycle counter");
        wr(5'd0, 32'd1);
        events = 64'd1 << 3;
        wr(5'd6, 32'h1);
        events = '0;
        rd(5'd16, 32'd7, "R7 one per clock");
        // R3 R5 R6 overflow and interrupt
        wr(5'd16, 32'hFFFF_FFFE);
        rd(5'd16, 32'hFFFF_FFFE, "R11 counter write");
        wr(5'd4, 32'h1);
        pulse(3, 2);
        rd(5'd16, 32'd0, "R3 wrapped");
        rd(5'd3, 32'd1, "R3 overflow flag");
        chk_irq(1'b1, "R6 irq raised");
        rd(5'd5, 32'd1, "R6 enable readback");
        wr(5'd3, 32'd0);
        rd(5'd3, 32'd1, "R5 zero mask keeps flag");
        wr(5'd5, 32'h1);
        chk_irq(1'b0, "R6 irq masked");
        rd(5'd3, 32'd1, "R6 flag kept while masked");
        wr(5'd4, 32'h1);
        chk_irq(1'b1, "R6 irq re-enabled");
        wr(5'd3, 32'h1);
        rd(5'd3, 32'd0, "R5 flag cleared");
        chk_irq(1'b0, "R6 irq after clear");
        wr(5'd16, 32'hFFFF_FFFF);
        events = 64'd1 << 3;
        wr(5'd3, 32'h1);
        events = '0;
        rd(5'd3, 32'd1, "R5 set wins over clear");
        wr(5'd3, 32'h1);
        // R11 write priority
        events = 64'd1 << 3;
        wr(5'd16, 32'd100);
        events = '0;
        rd(5'd16, 32'd100, "R11 write beats increment");
        // R10 control resets
        wr(5'd0, 32'd7);
        rd(5'd0, 32'd1, "R10 reset bits read zero");
        rd(5'd16, 32'd0, "R10 counter0 zeroed");
        rd(5'd17, 32'd0, "R10 counter1 zeroed");
        rd(5'd8, 32'd0, "R10 cycle zeroed");
        // R8 gate
        wr(5'd7, (32'd6 << 16) | 32'd5);
        rd(5'd7, 32'h0006_0005, "R8 config readback");
        wr(5'd1, 32'h8000_0001);
        repeat (3) step();
        rd(5'd8, 32'd0, "R8 idle holds");
        pulse(5, 1);
        repeat (10) step();
        pulse(6, 1);
        rd(5'd8, 32'd11, "R8 start to stop count");
        // R9 enables
        pulse(5, 1);
        wr(5'd2, 32'h8000_0000);
        repeat (5) step();
        rd(5'd8, 32'd12, "R9 enable bit31 clear");
        wr(5'd1, 32'h8000_0000);
        wr(5'd0, 32'd0);
        repeat (5) step();
        rd(5'd8, 32'd13, "R9 global disable");
        wr(5'd0, 32'd1);
        pulse(6, 1);
        rd(5'd8, 32'd14, "R9 resumed then stopped");
        // R3 64-bit wrap, R11 halves
        wr(5'd8, 32'hFFFF_FFFF);
        wr(5'd9, 32'd0);
        wr(5'd6, 32'h8000_0000);
        rd(5'd9, 32'd1, "R3 low carry");
        rd(5'd3, 32'd0, "R3 no flag on low carry");
        wr(5'd8, 32'hFFFF_FFFF);
        wr(5'd9, 32'hFFFF_FFFF);
        wr(5'd6, 32'h8000_0000);
        rd(5'd8, 32'd0, "R3 full wrap low");
        rd(5'd9, 32'd0, "R3 full wrap high");
        rd(5'd3, 32'h8000_0000, "R3 cycle flag");
        wr(5'd4, 32'h8000_0000);
        chk_irq(1'b1, "R6 cycle irq");
        wr(5'd9, 32'h55);
        wr(5'd8, 32'd7);
        rd(5'd9, 32'h55, "R11 high kept");
        rd(5'd8, 32'd7, "R11 low written");
        rd(5'd20, 32'd0, "R12 unused address");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule